// File: doc/BRIEF.md
# ISA Cycle Sequencer

This block is the master side of an ISA expansion bus. It runs its state machine on SYSCLK. A host offers one request at a time. Each request carries a 24-bit address, a cycle kind, a two-bit byte-lane mask and write data. The block then drives the address, the command strobe and the byte-high enable. It derives the standard-memory strobes, which reach only devices in the first megabyte. It samples two slave responses: the 16-bit memory decode and the zero-wait-state request.

Every cycle has an address phase of one SYSCLK, then a command phase. The command phase lasts a fixed number of SYSCLKs, chosen by the cycle's width and kind. A slave can cut it short by asserting the zero-wait-state input. When the strobes drop, the block raises `done` for one SYSCLK. On reads the captured data appears at `rdata` in that same SYSCLK.

Top module: `isa_cycle_seq`

## Requirements
- R1: A request is taken only when the block is idle and `req_kind` is 0 to 4. A request raised while a cycle runs is dropped, and so is a kind of 5 to 7. A dropped request starts no cycle and leaves the address of the running cycle unchanged.
- R2: The kind codes are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write and 4 refresh. For one SYSCLK after acceptance `busy` is high and all strobes are high. In the command phase exactly one of `memr_n`, `memw_n`, `ior_n` and `iow_n` is low: `memr_n` for codes 0 and 4, `memw_n` for 1, `ior_n` for 2, `iow_n` for 3.
- R3: A 16-bit memory cycle holds its command strobe low for 3 SYSCLKs. If `zero_ws_n` is low at the end of strobe SYSCLK j, the strobe lasts max(j,2) SYSCLKs.
- R4: An 8-bit memory cycle and an 8-bit I/O cycle hold the strobe low for 6 SYSCLKs. If `zero_ws_n` is low at the end of strobe SYSCLK j, the strobe lasts max(j,3) SYSCLKs.
- R5: An I/O cycle with lane mask 2'b11 is a 16-bit I/O cycle. Its strobe lasts 3 SYSCLKs whatever `zero_ws_n` does.
- R6: `smemr_n` and `smemw_n` go low only when address bits 23:20 are zero, and only on a memory or refresh cycle. Each goes low one SYSCLK after its main strobe and rises with it, so it is low for one SYSCLK fewer than the main strobe.
- R7: `sbhe_n` is low throughout a cycle whose lane-mask bit 1 is set. It stays high during refresh and when bit 1 is clear.
- R8: On memory and refresh cycles `sa` carries address bits 19:0 and `la_hi` carries address bits 23:17. On I/O cycles `sa` carries {4'h0, address bits 15:0} and `la_hi` is zero.
- R9: A refresh strobes `memr_n` for 3 SYSCLKs and ignores `zero_ws_n`. It leaves `rdata` unchanged.
- R10: `done` is high for exactly one SYSCLK, the first one after the strobe rises. On read cycles `rdata` then holds the `sd_in` value sampled at the end of the last strobe SYSCLK. On write cycles `sd_oe` is high and `sd_out` carries the write data during the cycle.
- R11: A memory cycle is 16-bit when `mem16_n` is low at the end of the address phase. Otherwise it is 8-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SYSCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 24 | Byte address |
| req_be | input | 2 | Lane mask, bit 1 = upper byte |
| req_wdata | input | 16 | Write data |
| mem16_n | input | 1 | Slave 16-bit memory decode, active low |
| zero_ws_n | input | 1 | Slave zero-wait-state request, active low |
| sd_in | input | 16 | Data bus as seen from the slave |
| busy | output | 1 | A cycle is running |
| done | output | 1 | One-SYSCLK end-of-cycle pulse |
| rdata | output | 16 | Captured read data |
| sa | output | 20 | System address |
| la_hi | output | 7 | Latched address bits 23:17 |
| sbhe_n | output | 1 | Byte-high enable, active low |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| smemr_n | output | 1 | Standard-memory read strobe |
| smemw_n | output | 1 | Standard-memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| sd_out | output | 16 | Write data to the bus |
| sd_oe | output | 1 | Write data output enable |

## Verification
The bound checker watches every cycle for these properties:
- the standard-memory strobes follow their main strobes with a one-SYSCLK lag and reach only the first megabyte;
- memory addresses have `sa[19:17]` equal to the low bits of `la_hi`;
- I/O addresses have their upper bits clear;
- no two command strobes are low at once;
- the address holds still while a strobe is low;
- `done` is a single pulse that coincides with a rising strobe.

Some behaviour shows only across a whole cycle, so only the bench sweeps can show it. The bench covers every kind, lane mask, width decode, zero-wait-state start point and address range. That is how it shows that strobe lengths depend on width and kind, that `zero_ws_n` is ignored on 16-bit I/O and refresh, that `sbhe_n` stays high on refresh, that read data is captured or held, and that requests made while busy are dropped.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int SA_W   = 20;
  localparam int IO_W   = 16;
  localparam int LA_LSB = 17;
  localparam int LA_W   = ADDR_W - LA_LSB;

  typedef enum logic [2:0] {
    K_MRD  = 3'd0,
    K_MWR  = 3'd1,
    K_IORD = 3'd2,
    K_IOWR = 3'd3,
    K_REF  = 3'd4
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_CMD  = 2'd2
  } seq_state_e;

  typedef struct packed {
    cyc_kind_e           kind;
    logic [ADDR_W-1:0]   addr;
    logic [1:0]          be;
    logic [DATA_W-1:0]   wdata;
  } cyc_req_t;
endpackage

// File: rtl/isa_seq_len.sv
module isa_seq_len
  import isa_seq_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int L16   = 3,
  parameter int S16   = 2,
  parameter int L8    = 6,
  parameter int S8    = 3,
  parameter int LREF  = 3
) (
  input  cyc_kind_e        kind,
  input  logic             wide,
  output logic [CNT_W-1:0] long_len,
  output logic [CNT_W-1:0] short_len,
  output logic             zws_en
);
  logic is_io;

  always_comb begin
    is_io = (kind == K_IORD) || (kind == K_IOWR);
    if (kind == K_REF) begin
      long_len  = CNT_W'(LREF);
      short_len = CNT_W'(LREF);
      zws_en    = 1'b0;
    end else if (wide) begin
      long_len  = CNT_W'(L16);
      short_len = CNT_W'(S16);
      zws_en    = !is_io;
    end else begin
      long_len  = CNT_W'(L8);
      short_len = CNT_W'(S8);
      zws_en    = 1'b1;
    end
  end
endmodule

// File: rtl/isa_seq_ctrl.sv
module isa_seq_ctrl
  import isa_seq_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int L16   = 3,
  parameter int S16   = 2,
  parameter int L8    = 6,
  parameter int S8    = 3,
  parameter int LREF  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  cyc_req_t          req_in,
  input  logic              mem16_n,
  input  logic              zero_ws_n,
  input  logic [DATA_W-1:0] sd_in,
  output seq_state_e        st_q,
  output cyc_req_t          cur_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              done_q,
  output logic [DATA_W-1:0] rdata_q
);
  seq_state_e        st_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              wide_q, wide_d;
  logic              load_en, done_d, rd_en;
  logic [CNT_W-1:0]  long_len, short_len;
  logic              zws_en, fin, kind_ok, is_mem, is_io, is_rd;

  isa_seq_len #(
    .CNT_W(CNT_W), .L16(L16), .S16(S16), .L8(L8), .S8(S8), .LREF(LREF)
  ) i_len (
    .kind(cur_q.kind), .wide(wide_q),
    .long_len(long_len), .short_len(short_len), .zws_en(zws_en)
  );

  always_comb begin
    kind_ok = req_in.kind <= K_REF;
    is_mem  = (cur_q.kind == K_MRD) || (cur_q.kind == K_MWR);
    is_io   = (cur_q.kind == K_IORD) || (cur_q.kind == K_IOWR);
    is_rd   = (cur_q.kind == K_MRD) || (cur_q.kind == K_IORD);
    fin     = (cnt_q == long_len) ||
              (zws_en && !zero_ws_n && (cnt_q >= short_len));
    st_d    = st_q;
    cnt_d   = cnt_q;
    wide_d  = wide_q;
    load_en = 1'b0;
    done_d  = 1'b0;
    rd_en   = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid && kind_ok) begin
        load_en = 1'b1;
        st_d    = ST_ADDR;
      end
      ST_ADDR: begin
        wide_d = is_mem ? !mem16_n : (is_io ? &cur_q.be : 1'b1);
        cnt_d  = CNT_W'(1);
        st_d   = ST_CMD;
      end
      ST_CMD: begin
        if (fin) begin
          st_d   = ST_IDLE;
          cnt_d  = '0;
          done_d = 1'b1;
          rd_en  = is_rd;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      wide_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wide_q <= wide_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (load_en) begin
      cur_q <= req_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= sd_in;
    end
  end
endmodule

// File: rtl/isa_seq_drv.sv
module isa_seq_drv
  import isa_seq_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int SMEM_DLY  = 1,
  parameter int LOW_BITS  = 20
) (
  input  seq_state_e        st,
  input  cyc_req_t          cur,
  input  logic [CNT_W-1:0]  cnt,
  output logic              busy,
  output logic [SA_W-1:0]   sa,
  output logic [LA_W-1:0]   la_hi,
  output logic              sbhe_n,
  output logic              memr_n,
  output logic              memw_n,
  output logic              smemr_n,
  output logic              smemw_n,
  output logic              ior_n,
  output logic              iow_n,
  output logic [DATA_W-1:0] sd_out,
  output logic              sd_oe
);
  logic on, cmd, is_io, low_mb, late, mr, mw;

  always_comb begin
    on     = st != ST_IDLE;
    cmd    = st == ST_CMD;
    is_io  = (cur.kind == K_IORD) || (cur.kind == K_IOWR);
    low_mb = cur.addr[ADDR_W-1:LOW_BITS] == '0;
    late   = cnt > CNT_W'(SMEM_DLY);
    mr     = cmd && ((cur.kind == K_MRD) || (cur.kind == K_REF));
    mw     = cmd && (cur.kind == K_MWR);
    busy    = on;
    memr_n  = !mr;
    memw_n  = !mw;
    smemr_n = !(mr && low_mb && late);
    smemw_n = !(mw && low_mb && late);
    ior_n   = !(cmd && (cur.kind == K_IORD));
    iow_n   = !(cmd && (cur.kind == K_IOWR));
    sbhe_n  = !(on && cur.be[1] && (cur.kind != K_REF));
    sa      = '0;
    la_hi   = '0;
    if (on) begin
      if (is_io) begin
        sa = {{(SA_W-IO_W){1'b0}}, cur.addr[IO_W-1:0]};
      end else begin
        sa    = cur.addr[SA_W-1:0];
        la_hi = cur.addr[ADDR_W-1:LA_LSB];
      end
    end
    sd_oe  = on && ((cur.kind == K_MWR) || (cur.kind == K_IOWR));
    sd_out = sd_oe ? cur.wdata : '0;
  end
endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_seq_pkg::*;
#(
  parameter int L16      = 3,
  parameter int S16      = 2,
  parameter int L8       = 6,
  parameter int S8       = 3,
  parameter int LREF     = 3,
  parameter int SMEM_DLY = 1,
  parameter int LOW_BITS = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic [23:0] req_addr,
  input  logic [1:0]  req_be,
  input  logic [15:0] req_wdata,
  input  logic        mem16_n,
  input  logic        zero_ws_n,
  input  logic [15:0] sd_in,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic [19:0] sa,
  output logic [6:0]  la_hi,
  output logic        sbhe_n,
  output logic        memr_n,
  output logic        memw_n,
  output logic        smemr_n,
  output logic        smemw_n,
  output logic        ior_n,
  output logic        iow_n,
  output logic [15:0] sd_out,
  output logic        sd_oe
);
  localparam int MAXL  = (L8 > L16) ? ((L8 > LREF) ? L8 : LREF)
                                    : ((L16 > LREF) ? L16 : LREF);
  localparam int CNT_W = $clog2(MAXL + 1);

  logic             rst_s1, rst_s2;
  seq_state_e       st;
  cyc_req_t         req_in, cur;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  always_comb begin
    req_in.kind  = cyc_kind_e'(req_kind);
    req_in.addr  = req_addr;
    req_in.be    = req_be;
    req_in.wdata = req_wdata;
  end

  isa_seq_ctrl #(
    .CNT_W(CNT_W), .L16(L16), .S16(S16), .L8(L8), .S8(S8), .LREF(LREF)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_s2), .req_valid(req_valid), .req_in(req_in),
    .mem16_n(mem16_n), .zero_ws_n(zero_ws_n), .sd_in(sd_in),
    .st_q(st), .cur_q(cur), .cnt_q(cnt), .done_q(done), .rdata_q(rdata)
  );

  isa_seq_drv #(
    .CNT_W(CNT_W), .SMEM_DLY(SMEM_DLY), .LOW_BITS(LOW_BITS)
  ) i_drv (
    .st(st), .cur(cur), .cnt(cnt), .busy(busy), .sa(sa), .la_hi(la_hi),
    .sbhe_n(sbhe_n), .memr_n(memr_n), .memw_n(memw_n),
    .smemr_n(smemr_n), .smemw_n(smemw_n), .ior_n(ior_n), .iow_n(iow_n),
    .sd_out(sd_out), .sd_oe(sd_oe)
  );
endmodule

// File: rtl/isa_cycle_seq_chk.sv
module isa_cycle_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic [19:0] sa,
  input logic [6:0]  la_hi,
  input logic        memr_n,
  input logic        memw_n,
  input logic        smemr_n,
  input logic        smemw_n,
  input logic        ior_n,
  input logic        iow_n
);
  a_r6_smemr_lags: assert property (@(posedge clk) disable iff (!rst_n)
    !smemr_n |-> (!memr_n && !$past(memr_n)));
  a_r6_smemw_lags: assert property (@(posedge clk) disable iff (!rst_n)
    !smemw_n |-> (!memw_n && !$past(memw_n)));
  a_r6_first_mb: assert property (@(posedge clk) disable iff (!rst_n)
    (!smemr_n || !smemw_n) |-> (la_hi[6:3] == 4'h0));
  a_r8_mem_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (!memr_n || !memw_n) |-> (sa[19:17] == la_hi[2:0]));
  a_r8_io_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (!ior_n || !iow_n) |-> (sa[19:16] == 4'h0 && la_hi == 7'h0));
  a_r2_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~memr_n, ~memw_n, ~ior_n, ~iow_n}) <= 1);
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!memr_n && !$past(memr_n)) |-> $stable(sa));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (memr_n && memw_n && ior_n && iow_n));
  a_r10_end_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(memr_n) || $rose(memw_n) || $rose(ior_n) || $rose(iow_n)) |-> done);
endmodule

bind isa_cycle_seq isa_cycle_seq_chk i_chk (.*);

// File: tb/test_isa_cycle_seq.sv
`timescale 1ns/1ps
module test_isa_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [23:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        mem16_n, zero_ws_n;
  logic [15:0] sd_in;
  logic        busy, done, sbhe_n, memr_n, memw_n, smemr_n, smemw_n;
  logic        ior_n, iow_n, sd_oe;
  logic [15:0] rdata, sd_out;
  logic [19:0] sa;
  logic [6:0]  la_hi;

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_rd = 16'h0;
  int it = 0;

  always #5 clk = ~clk;

  isa_cycle_seq i_isa_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .mem16_n(mem16_n), .zero_ws_n(zero_ws_n), .sd_in(sd_in),
    .busy(busy), .done(done), .rdata(rdata), .sa(sa), .la_hi(la_hi),
    .sbhe_n(sbhe_n), .memr_n(memr_n), .memw_n(memw_n),
    .smemr_n(smemr_n), .smemw_n(smemw_n), .ior_n(ior_n), .iow_n(iow_n),
    .sd_out(sd_out), .sd_oe(sd_oe)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    finish_run();
  end

  task automatic run(input int kind, input logic [23:0] addr, input logic [1:0] be,
                     input bit m16, input int zat);
    bit mem = (kind == 0) || (kind == 1);
    bit io  = (kind == 2) || (kind == 3);
    bit rf  = (kind == 4);
    bit rd  = (kind == 0) || (kind == 2);
    bit wr  = (kind == 1) || (kind == 3);
    bit wide = mem ? m16 : (io ? (be == 2'b11) : 1'b1);
    int lng = rf ? 3 : (wide ? 3 : 6);
    int sht = rf ? 3 : (wide ? 2 : 3);
    bit zen = !rf && !(io && wide);
    int expl = (zen && zat != 0 && zat <= lng) ? ((zat > sht) ? zat : sht) : lng;
    bit lowmb = (addr[23:20] == 4'h0) && !io;
    int expsm = lowmb ? expl - 1 : 0;
    logic [19:0] exp_sa = io ? {4'h0, addr[15:0]} : addr[19:0];
    logic [6:0]  exp_la = io ? 7'h0 : addr[23:17];
    logic exp_sbhe = !(be[1] && !rf);
    logic [15:0] rp = 16'h3C00 ^ 16'(it * 97);
    int n = 0, sm = 0, stray = 0, badaddr = 0, badsb = 0, badwr = 0;
    bit got = 0;
    string tag;
    tag = rf ? "R9" : (io && wide) ? "R5" : (mem && wide) ? "R3" : "R4";
    it++;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'(kind); req_addr = addr; req_be = be;
    req_wdata = ~rp; mem16_n = !m16; zero_ws_n = 1'b1; sd_in = rp;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && memr_n && memw_n && ior_n && iow_n, "R2 address phase", busy, 1);
    for (int t = 0; t < 20 && !got; t++) begin
      logic stb;
      stb = (kind == 0 || kind == 4) ? memr_n : (kind == 1) ? memw_n :
            (kind == 2) ? ior_n : iow_n;
      if (done) begin
        got = 1;
        chk(memr_n && memw_n && ior_n && iow_n && smemr_n && smemw_n,
            "R10 strobes high at done", 0, 0);
      end else if (!stb) begin
        n++;
        if (!smemr_n || !smemw_n) sm++;
        if ($countones({~memr_n, ~memw_n, ~ior_n, ~iow_n}) != 1) stray++;
        if (sa != exp_sa || la_hi != exp_la) badaddr++;
        if (sbhe_n != exp_sbhe) badsb++;
        if (wr && (!sd_oe || sd_out != ~rp)) badwr++;
        if (n == 1) begin req_valid = 1'b1; req_addr = addr ^ 24'h5A5A5A; req_kind = 3'(kind); end
        if (n == 2) req_valid = 1'b0;
        zero_ws_n = !(zat != 0 && n >= zat);
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    zero_ws_n = 1'b1;
    chk(got, "R10 done seen", got, 1);
    chk(n == expl, {tag, " strobe length"}, n, expl);
    if (mem && zat == 0) chk(n == (m16 ? 3 : 6), "R11 width decode", n, m16 ? 3 : 6);
    chk(sm == expsm, "R6 standard-memory strobe", sm, expsm);
    chk(stray == 0, "R2 strobe kind", stray, 0);
    chk(badaddr == 0, "R8 address", badaddr, 0);
    chk(badsb == 0, "R7 byte-high enable", badsb, 0);
    if (wr) chk(badwr == 0, "R10 write data", badwr, 0);
    if (rd) exp_rd = rp;
    chk(rdata == exp_rd, rf ? "R9 rdata held" : "R10 rdata", rdata, exp_rd);
    chk(!busy && !done && memr_n && memw_n && ior_n && iow_n,
        "R1 busy request dropped", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_addr = '0; req_be = '0;
    req_wdata = '0; mem16_n = 1'b1; zero_ws_n = 1'b1; sd_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && rdata == 16'h0 && memr_n && memw_n && ior_n && iow_n
        && smemr_n && smemw_n && sbhe_n && !sd_oe, "R10 reset state", rdata, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 5; k++)
      for (int b = 1; b < 4; b++)
        for (int m = 0; m < 2; m++)
          for (int z = 0; z < 5; z++)
            for (int a = 0; a < 2; a++)
              run(k, a ? 24'hB71E9A : 24'h05A3C6, 2'(b), m[0], z);
    // R1: an undefined kind code is not accepted
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd6; req_addr = 24'h012345;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!busy, "R1 undefined kind ignored", busy, 0);
    @(negedge clk);
    chk(!busy && memr_n && memw_n && ior_n && iow_n, "R1 no cycle from kind 6", busy, 0);
    finish_run();
  end
endmodule